// File: doc/BRIEF.md
# Audio Tick Interrupt Generator

This block raises a periodic interrupt that stays in step with one chosen audio event stream. Each event is a one-clock strobe, such as a read or write of a transmit or receive sample buffer. One strobe stands for one stereo sample pair. A source-select register chooses which strobe line advances an internal event counter. A count register sets how many selected events make up one period. When the period completes, the block emits a single-clock tick and sets a sticky status bit. Software clears that bit by writing 1 to it.

The block takes in no buffer level, fill state or buffer reset. The tick depends only on the strobes, so it keeps running while the buffer behind the chosen source is held in reset.

The interface is plain control and status. It has no data stream, so there is no valid/ready handshake and no back-pressure. Register writes are single-cycle enable pulses that carry their data alongside.

Top module: `audio_tick_gen`

## Requirements
- R1: After reset, `tick` and `status` are 0, the source select is 0 and the count field is 0.
- R2: With source code k below NUM_SRC, only strobes on `ev_strobe[k]` are counted, and strobes on every other line have no effect on `tick`.
- R3: Source codes from NUM_SRC up to 2**SRC_W-1 select a constant-zero source, so `tick` never rises while such a code is held.
- R4: With count field N (1 to 255), `tick` is high for exactly the one clock that follows the edge sampling the Nth selected strobe since the last tick or restart. The ticks then repeat after every further N strobes.
- R5: A count field of 0 behaves as 1, so every selected strobe produces a tick one clock later.
- R6: A write pulse on `src_wr` or `cnt_wr` resets the event progress to zero. A strobe sampled in the same clock as a write is not counted, and `tick` is low in the clock after the write.
- R7: Strobes on back-to-back clocks are each counted, with at most one event counted per clock. With a count of 1, this gives a tick on consecutive clocks.
- R8: `status` goes to 1 in the same clock as `tick` and holds until a clock in which `status_clr` is 1. If a tick fires in that same clock, the set wins and `status` stays 1. A clock with `status_clr` at 0 leaves `status` unchanged.
- R9: The gaps between strobes do not change the count. Idle clocks of any length between events neither advance nor reset the progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | NUM_SRC | One-clock event strobes, one line per audio source |
| src_wr | input | 1 | Write pulse for the source-select register |
| src_wdata | input | SRC_W | New source code |
| cnt_wr | input | 1 | Write pulse for the count register |
| cnt_wdata | input | CNT_W | New events-per-tick value (0 acts as 1) |
| status_clr | input | 1 | Write-1-to-clear for the sticky status bit |
| tick | output | 1 | One-clock interrupt pulse |
| status | output | 1 | Sticky copy of the tick |

## Verification
The bench builds the block with NUM_SRC = 6, SRC_W = 3 and CNT_W = 8. This leaves codes 6 and 7 unused, so the constant-zero selection is reachable. The 8-bit count reaches its top value of 255 in a few hundred clocks, so the full-range period and the zero-as-one case are both exercised. Random strobe patterns across all six lines, mixed with register writes and clears, drive the reference model and the design side by side.

// File: rtl/ati_pkg.sv
package ati_pkg;

  // Effective events-per-tick: a programmed zero behaves as one.
  function automatic int unsigned eff_limit(input int unsigned programmed);
    return (programmed == 0) ? 1 : programmed;
  endfunction

endpackage

// File: rtl/ati_cfg_regs.sv
module ati_cfg_regs #(
  parameter int SRC_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_wr,
  input  logic [SRC_W-1:0] src_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [SRC_W-1:0] src_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             restart
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_wr) src_q <= src_wdata;
      if (cnt_wr) cnt_q <= cnt_wdata;
    end
  end

  // Any configuration write restarts the period.
  assign restart = src_wr | cnt_wr;

endmodule

// File: rtl/ati_src_sel.sv
module ati_src_sel #(
  parameter int NUM_SRC = 6,
  parameter int SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0] ev_strobe,
  input  logic [SRC_W-1:0]   src_q,
  output logic               sel_ev
);

  localparam int CODES = 1 << SRC_W;

  logic [CODES-1:0] lane;

  for (genvar i = 0; i < CODES; i++) begin : g_lane
    if (i < NUM_SRC) begin : g_live
      assign lane[i] = ev_strobe[i];
    end else begin : g_dead
      assign lane[i] = 1'b0;
    end
  end

  assign sel_ev = lane[src_q];

endmodule

// File: rtl/ati_evt_cnt.sv
module ati_evt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_ev,
  input  logic             restart,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] count_q,
  output logic             tick
);

  import ati_pkg::*;

  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] limit;
  logic [EXT_W-1:0] next_cnt;
  logic             wrap;

  always_comb begin
    limit    = EXT_W'(eff_limit(int'(cnt_q)));
    next_cnt = {1'b0, count_q} + EXT_W'(1);
    wrap     = sel_ev && !restart && (next_cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= wrap;
      if (restart || wrap) count_q <= '0;
      else if (sel_ev)     count_q <= next_cnt[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/ati_status.sv
module ati_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic status_clr,
  output logic status
);

  // Set and output are aligned with the tick register; set beats clear.
  logic held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= tick | (held_q & ~status_clr);
  end

  assign status = tick | held_q;

endmodule

// File: rtl/audio_tick_gen.sv
module audio_tick_gen #(
  parameter int NUM_SRC = 6,
  parameter int SRC_W   = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev_strobe,
  input  logic               src_wr,
  input  logic [SRC_W-1:0]   src_wdata,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               status_clr,
  output logic               tick,
  output logic               status
);

  logic [SRC_W-1:0] src_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] count_q;
  logic             restart;
  logic             sel_ev;

  ati_cfg_regs #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .src_wr(src_wr), .src_wdata(src_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .src_q(src_q), .cnt_q(cnt_q), .restart(restart)
  );

  ati_src_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sel (
    .ev_strobe(ev_strobe), .src_q(src_q), .sel_ev(sel_ev)
  );

  ati_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sel_ev(sel_ev), .restart(restart),
    .cnt_q(cnt_q), .count_q(count_q), .tick(tick)
  );

  ati_status u_stat (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .status_clr(status_clr), .status(status)
  );

endmodule

// File: rtl/ati_checker.sv
module ati_checker #(
  parameter int NUM_SRC = 6,
  parameter int SRC_W   = 3,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] src_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] count_q,
  input logic             sel_ev,
  input logic             restart,
  input logic             status_clr,
  input logic             tick,
  input logic             status
);

  AST_TICK_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(sel_ev) && !$past(restart))); // R4
  AST_PROGRESS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (count_q < cnt_q)); // R4
  AST_UNUSED_SRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_q) >= NUM_SRC) |-> !sel_ev); // R3
  AST_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && sel_ev && !restart) |=> tick); // R5
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R6
  AST_STATUS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> status); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) && !$past(status_clr)) |-> status); // R8

endmodule

bind audio_tick_gen ati_checker #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_q(src_q), .cnt_q(cnt_q), .count_q(count_q),
  .sel_ev(sel_ev), .restart(restart), .status_clr(status_clr),
  .tick(tick), .status(status)
);

// File: tb/tb_audio_tick_gen.sv
module tb_audio_tick_gen;

  localparam int NUM_SRC = 6;
  localparam int SRC_W   = 3;
  localparam int CNT_W   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NUM_SRC-1:0] ev_strobe;
  logic src_wr, cnt_wr, status_clr;
  logic [SRC_W-1:0] src_wdata;
  logic [CNT_W-1:0] cnt_wdata;
  logic tick, status;

  always #5 clk = ~clk;

  audio_tick_gen #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CNT_W(CNT_W)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // Reference model state
  int m_src, m_cnt, m_prog;
  bit m_tick, m_status, m_held;

  task automatic model_edge();
    bit ev, fire;
    int lim;
    if (!rst_n) begin
      m_src = 0; m_cnt = 0; m_prog = 0; m_tick = 0; m_held = 0;
    end else begin
      ev   = (m_src < NUM_SRC) ? ev_strobe[m_src] : 1'b0;
      fire = 0;
      lim  = (m_cnt == 0) ? 1 : m_cnt;
      if (src_wr || cnt_wr) m_prog = 0;
      else if (ev) begin
        m_prog++;
        if (m_prog >= lim) begin m_prog = 0; fire = 1; end
      end
      m_held = m_tick | (m_held & !status_clr);
      m_tick = fire;
      if (src_wr) m_src = int'(src_wdata);
      if (cnt_wr) m_cnt = int'(cnt_wdata);
    end
    m_status = m_tick | m_held;
  endtask

  task automatic compare();
    n_cmp++;
    if (tick !== m_tick || status !== m_status) begin
      n_bad++;
      $display("FAIL %s t=%0t tick=%b status=%b expected tick=%b status=%b",
               cur_req, $time, tick, status, m_tick, m_status);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    ev_strobe = '0; src_wr = 0; cnt_wr = 0; status_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_src(input int v);
    src_wr = 1; src_wdata = SRC_W'(v); step();
  endtask

  task automatic wr_cnt(input int v);
    cnt_wr = 1; cnt_wdata = CNT_W'(v); step();
  endtask

  task automatic strobe(input int line, input int gap);
    ev_strobe[line] = 1'b1; step();
    idle(gap);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ev_strobe = '0; src_wr = 0; cnt_wr = 0; status_clr = 0;
    src_wdata = '0; cnt_wdata = '0;
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    idle(2);

    // r5_ zero count acts as one after reset
    cur_req = "R5";
    for (int i = 0; i < 4; i++) strobe(0, i);

    // R4 count of three on source 0, varied gaps (R9)
    cur_req = "R4";
    wr_cnt(3);
    for (int i = 0; i < 9; i++) strobe(0, i % 4);
    cur_req = "R9";
    for (int i = 0; i < 6; i++) strobe(0, 7 * (i % 2));

    // R2 source 2: other lines ignored
    cur_req = "R2";
    wr_src(2);
    for (int i = 0; i < 8; i++) begin
      ev_strobe = 6'b111011; step();
    end
    for (int i = 0; i < 6; i++) strobe(2, 1);

    // R3 unused codes
    cur_req = "R3";
    wr_src(6);
    for (int i = 0; i < 10; i++) begin ev_strobe = '1; step(); end
    wr_src(7);
    for (int i = 0; i < 10; i++) begin ev_strobe = '1; step(); end

    // R7 back-to-back strobes with count 1
    cur_req = "R7";
    wr_src(4); wr_cnt(1);
    for (int i = 0; i < 6; i++) begin ev_strobe[4] = 1; step(); end
    wr_cnt(2);
    for (int i = 0; i < 7; i++) begin ev_strobe[4] = 1; step(); end

    // R6 restart by write, including strobe on write cycle
    cur_req = "R6";
    wr_cnt(3);
    strobe(4, 0); strobe(4, 0);
    ev_strobe[4] = 1; src_wr = 1; src_wdata = 3'd4; step();
    strobe(4, 0); strobe(4, 0); strobe(4, 2);
    strobe(4, 0); strobe(4, 0);
    ev_strobe[4] = 1; cnt_wr = 1; cnt_wdata = 8'd3; step();
    strobe(4, 0); strobe(4, 0); strobe(4, 2);

    // R8 sticky status: hold, clear, set-beats-clear
    cur_req = "R8";
    idle(3);
    status_clr = 1; step();
    idle(2);
    wr_cnt(1);
    ev_strobe[4] = 1; step();
    status_clr = 1; step();
    status_clr = 1; step();
    ev_strobe[4] = 1; step();
    ev_strobe[4] = 1; status_clr = 1; step();
    status_clr = 1; step();
    idle(2);

    // R4 full-range period
    cur_req = "R4";
    wr_cnt(255);
    for (int i = 0; i < 520; i++) strobe(4, 0);

    // Mixed random traffic
    cur_req = "R2";
    wr_cnt(5); wr_src(1);
    for (int i = 0; i < 3000; i++) begin
      ev_strobe = NUM_SRC'($urandom);
      status_clr = ($urandom % 9) == 0;
      if (($urandom % 97) == 0) begin src_wr = 1; src_wdata = SRC_W'($urandom); end
      if (($urandom % 131) == 0) begin cnt_wr = 1; cnt_wdata = CNT_W'($urandom % 7); end
      step();
    end

    // R1 reset mid-run
    cur_req = "R1";
    rst_n = 0; step(); step();
    rst_n = 1; step();
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule